// File: doc/BRIEF.md
# Coprocessor Firmware Image Loader

This block brings a small coprocessor up from a firmware image. The image arrives as 32-bit words on a valid/ready stream. A start pulse comes with it and carries the total image length in bytes. The block works out the byte order of the image from its first word and normalises every later word to native order. It checks the two section sizes declared in the header against each other, against the size of each target memory and against the total length.

If the sizes are good, the block does the following in order:
- It puts the coprocessor into reset if the coprocessor is running.
- It zeroes the part of each target memory that the image will use.
- It streams the instruction words and then the data words into the two memory write ports.
- It keeps a running wrapping sum and compares that sum with the trailing checksum word.

Only when the checksum matches does the block clear both mailboxes and write the control register twice, first to turn the clock on and then to release reset. The result stays on `done`/`err_code` until the next start pulse.

Top module: `cpfw_loader`

## Requirements
- R1: A first word of 0xfe0101fe selects native (little-endian) order and 0xfe1010fe selects byte-reversed (big-endian) order. The comparison uses the word exactly as received. Any other first word ends the load with `err_code` = 1. After that one word the block accepts no more stream words, makes no memory writes and makes no register writes.
- R2: In a big-endian image, every word after the magic word is byte-reversed before it is used. This covers the header fields, the payload and the checksum.
- R3: The header is five words: magic, sequence, version, instruction-section byte size, data-section byte size. The load fails with `err_code` = 2, and with no memory or register write, in any of these cases: either size is not a multiple of 4; 24 plus both sizes differs from `img_len`; or a section holds more words than its memory (2^IMEM_AW or 2^DMEM_AW words).
- R4: The payload word at image position 5+k is written to instruction address k. The data-section word j, which follows the instruction section, is written to data address j.
- R5: Before any payload word is written, every address that the section will occupy is written with zero, in both memories. Addresses beyond a section's length are never written.
- R6: Once the sizes pass, if bit 0 of `cp_ctrl_q` is 0 (coprocessor running), the block writes the control register (`reg_sel` = 0) with `cp_ctrl_q` with bit 0 set. This happens before any memory write. If bit 0 is already 1, the block makes no such write.
- R7: The last word must equal the 32-bit wrapping sum of the five header words and all payload words, all in native order. On a mismatch `err_code` becomes 3, and no mailbox write or release write follows.
- R8: After a checksum match the block makes exactly four register writes on consecutive cycles, in this order: 0 to the mailbox toward the coprocessor (`reg_sel` = 1); 0 to the mailbox toward the host (`reg_sel` = 2); the control value with bit 2 cleared; then the control value with bits 2 and 0 cleared. After these writes it raises `done` with `err_code` = 0.
- R9: `done` and `err_code` hold their values until the next `start`. `busy` is high only while a load is in progress. `s_ready` is never high while `busy` is low.
- R10: Either section, or both, may have size zero. Such a load completes normally and makes no writes to the empty memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a load; accepted while idle or done |
| img_len | input | 32 | Total image length in bytes, captured on start |
| s_valid | input | 1 | Image word valid |
| s_ready | output | 1 | Block accepts an image word |
| s_data | input | 32 | Image word as received |
| imem_we | output | 1 | Instruction memory write enable |
| imem_addr | output | IMEM_AW | Instruction memory word address |
| imem_wdata | output | 32 | Instruction memory write data |
| dmem_we | output | 1 | Data memory write enable |
| dmem_addr | output | DMEM_AW | Data memory word address |
| dmem_wdata | output | 32 | Data memory write data |
| reg_we | output | 1 | Coprocessor register write strobe |
| reg_sel | output | 2 | 0 control, 1 mailbox toward coprocessor, 2 mailbox toward host |
| reg_wdata | output | 32 | Register write data |
| cp_ctrl_q | input | 32 | Current control register value |
| busy | output | 1 | Load in progress |
| done | output | 1 | Load finished (success or error) |
| err_code | output | 2 | 0 ok, 1 bad magic, 2 bad size, 3 bad checksum |

## Verification
The bench builds the block with IMEM_AW = 4 and DMEM_AW = 3, which gives a 16-word instruction memory and an 8-word data memory. With these depths, images that fill a memory exactly and images one word too large for it take only a couple of dozen stream words. This brings the region-overflow size error and full-depth loads within reach alongside many random loads. Random images mix both byte orders, section lengths from zero to full depth, and control values with the coprocessor either running or already held in reset.

// File: rtl/cpfw_pkg.sv
package cpfw_pkg;

  localparam logic [31:0] MAGIC_LE = 32'hfe0101fe;
  localparam logic [31:0] MAGIC_BE = 32'hfe1010fe;

  localparam int CTRL_RST_BIT    = 0;
  localparam int CTRL_CLKOFF_BIT = 2;
  localparam int HDR_WORDS       = 5;

  typedef enum logic [1:0] {
    ERR_NONE  = 2'd0,
    ERR_MAGIC = 2'd1,
    ERR_SIZE  = 2'd2,
    ERR_CSUM  = 2'd3
  } cpfw_err_e;

  typedef enum logic [1:0] {
    SEL_CTRL    = 2'd0,
    SEL_MB_CP   = 2'd1,
    SEL_MB_HOST = 2'd2,
    SEL_NONE    = 2'd3
  } cpfw_sel_e;

  typedef enum logic [3:0] {
    S_IDLE, S_HDR, S_CHK, S_HALT, S_CLR_I, S_CLR_D, S_LOAD_I, S_LOAD_D,
    S_CSUM, S_MB_CP, S_MB_HOST, S_CLK_ON, S_RUN, S_DONE
  } cpfw_state_e;

endpackage

// File: rtl/cpfw_byte_order.sv
module cpfw_byte_order #(
  parameter int W = 32
) (
  input  logic         big,
  input  logic [W-1:0] raw,
  output logic [W-1:0] norm
);
  localparam int NB = W / 8;

  logic [W-1:0] rev;

  for (genvar b = 0; b < NB; b++) begin : g_byte
    assign rev[8*b +: 8] = raw[W-8-8*b +: 8];
  end

  assign norm = big ? rev : raw;
endmodule

// File: rtl/cpfw_csum_acc.sv
module cpfw_csum_acc #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         add,
  input  logic [W-1:0] val,
  output logic [W-1:0] sum
);
  logic [W-1:0] sum_d;
  logic         sum_en;

  always_comb begin
    sum_en = clr | add;
    sum_d  = clr ? '0 : (sum + val);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sum <= '0;
    else if (sum_en) sum <= sum_d;
  end
endmodule

// File: rtl/cpfw_size_check.sv
module cpfw_size_check #(
  parameter int IMEM_AW = 6,
  parameter int DMEM_AW = 5
) (
  input  logic [31:0] isz,
  input  logic [31:0] dsz,
  input  logic [31:0] total,
  output logic        ok
);
  import cpfw_pkg::*;

  localparam logic [31:0] ILIM     = 32'(1) << IMEM_AW;
  localparam logic [31:0] DLIM     = 32'(1) << DMEM_AW;
  localparam logic [33:0] OVERHEAD = 34'((HDR_WORDS + 1) * 4);

  logic        aligned;
  logic        fits;
  logic [33:0] span;

  always_comb begin
    aligned = (isz[1:0] == 2'b00) && (dsz[1:0] == 2'b00);
    fits    = ({2'b00, isz[31:2]} <= ILIM) && ({2'b00, dsz[31:2]} <= DLIM);
    span    = {2'b00, isz} + {2'b00, dsz} + OVERHEAD;
    ok      = aligned && fits && (span == {2'b00, total});
  end
endmodule

// File: rtl/cpfw_loader.sv
module cpfw_loader
  import cpfw_pkg::*;
#(
  parameter int IMEM_AW = 6,
  parameter int DMEM_AW = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [31:0]        img_len,
  input  logic               s_valid,
  output logic               s_ready,
  input  logic [31:0]        s_data,
  output logic               imem_we,
  output logic [IMEM_AW-1:0] imem_addr,
  output logic [31:0]        imem_wdata,
  output logic               dmem_we,
  output logic [DMEM_AW-1:0] dmem_addr,
  output logic [31:0]        dmem_wdata,
  output logic               reg_we,
  output logic [1:0]         reg_sel,
  output logic [31:0]        reg_wdata,
  input  logic [31:0]        cp_ctrl_q,
  output logic               busy,
  output logic               done,
  output logic [1:0]         err_code
);

  localparam int CW = ((IMEM_AW > DMEM_AW) ? IMEM_AW : DMEM_AW) + 1;
  localparam logic [31:0] RST_MASK = 32'(1) << CTRL_RST_BIT;
  localparam logic [31:0] CLK_MASK = 32'(1) << CTRL_CLKOFF_BIT;

  cpfw_state_e state_q, state_d;
  cpfw_err_e   err_q, err_d;
  cpfw_sel_e   sel;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [2:0]    hidx_q, hidx_d;
  logic          big_q, big_d;
  logic [31:0]   isz_q, isz_d, dsz_q, dsz_d, len_q, len_d, shadow_q, shadow_d;

  logic        acc, sum_clr, sum_add, size_ok, i_more, d_more;
  logic [31:0] word_n, sum_q, cnt_ext;

  // Both legal magic values read the same in either byte order, so the
  // normaliser may use the previous image's order while word 0 passes.
  cpfw_byte_order #(.W(32)) u_order (
    .big  (big_q),
    .raw  (s_data),
    .norm (word_n)
  );

  cpfw_csum_acc #(.W(32)) u_sum (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (sum_clr),
    .add   (sum_add),
    .val   (word_n),
    .sum   (sum_q)
  );

  cpfw_size_check #(.IMEM_AW(IMEM_AW), .DMEM_AW(DMEM_AW)) u_size (
    .isz   (isz_q),
    .dsz   (dsz_q),
    .total (len_q),
    .ok    (size_ok)
  );

  assign acc     = s_valid && s_ready;
  assign cnt_ext = {{(32-CW){1'b0}}, cnt_q};
  assign i_more  = cnt_ext < {2'b00, isz_q[31:2]};
  assign d_more  = cnt_ext < {2'b00, dsz_q[31:2]};

  always_comb begin
    state_d    = state_q;
    err_d      = err_q;
    cnt_d      = cnt_q;
    hidx_d     = hidx_q;
    big_d      = big_q;
    isz_d      = isz_q;
    dsz_d      = dsz_q;
    len_d      = len_q;
    shadow_d   = shadow_q;
    sum_clr    = 1'b0;
    sum_add    = 1'b0;
    s_ready    = 1'b0;
    imem_we    = 1'b0;
    dmem_we    = 1'b0;
    imem_wdata = '0;
    dmem_wdata = '0;
    reg_we     = 1'b0;
    sel        = SEL_CTRL;
    reg_wdata  = '0;

    case (state_q)
      S_IDLE, S_DONE: begin
        if (start) begin
          state_d = S_HDR;
          hidx_d  = '0;
          err_d   = ERR_NONE;
          len_d   = img_len;
          sum_clr = 1'b1;
        end
      end
      S_HDR: begin
        s_ready = 1'b1;
        if (acc) begin
          sum_add = 1'b1;
          hidx_d  = hidx_q + 3'd1;
          case (hidx_q)
            3'd0: begin
              if (s_data == MAGIC_BE)      big_d = 1'b1;
              else if (s_data == MAGIC_LE) big_d = 1'b0;
              else begin
                err_d   = ERR_MAGIC;
                state_d = S_DONE;
              end
            end
            3'd3: isz_d = word_n;
            3'd4: begin
              dsz_d   = word_n;
              state_d = S_CHK;
            end
            default: ;
          endcase
        end
      end
      S_CHK: begin
        cnt_d = '0;
        if (!size_ok) begin
          err_d   = ERR_SIZE;
          state_d = S_DONE;
        end else if (!cp_ctrl_q[CTRL_RST_BIT]) begin
          state_d = S_HALT;
        end else begin
          state_d = S_CLR_I;
        end
      end
      S_HALT: begin
        reg_we    = 1'b1;
        sel       = SEL_CTRL;
        reg_wdata = cp_ctrl_q | RST_MASK;
        state_d   = S_CLR_I;
      end
      S_CLR_I: begin
        if (i_more) begin
          imem_we = 1'b1;
          cnt_d   = cnt_q + 1'b1;
        end else begin
          cnt_d   = '0;
          state_d = S_CLR_D;
        end
      end
      S_CLR_D: begin
        if (d_more) begin
          dmem_we = 1'b1;
          cnt_d   = cnt_q + 1'b1;
        end else begin
          cnt_d   = '0;
          state_d = S_LOAD_I;
        end
      end
      S_LOAD_I: begin
        imem_wdata = word_n;
        if (i_more) begin
          s_ready = 1'b1;
          if (acc) begin
            imem_we = 1'b1;
            sum_add = 1'b1;
            cnt_d   = cnt_q + 1'b1;
          end
        end else begin
          cnt_d   = '0;
          state_d = S_LOAD_D;
        end
      end
      S_LOAD_D: begin
        dmem_wdata = word_n;
        if (d_more) begin
          s_ready = 1'b1;
          if (acc) begin
            dmem_we = 1'b1;
            sum_add = 1'b1;
            cnt_d   = cnt_q + 1'b1;
          end
        end else begin
          cnt_d   = '0;
          state_d = S_CSUM;
        end
      end
      S_CSUM: begin
        s_ready = 1'b1;
        if (acc) begin
          if (word_n == sum_q) state_d = S_MB_CP;
          else begin
            err_d   = ERR_CSUM;
            state_d = S_DONE;
          end
        end
      end
      S_MB_CP: begin
        reg_we   = 1'b1;
        sel      = SEL_MB_CP;
        shadow_d = cp_ctrl_q;
        state_d  = S_MB_HOST;
      end
      S_MB_HOST: begin
        reg_we  = 1'b1;
        sel     = SEL_MB_HOST;
        state_d = S_CLK_ON;
      end
      S_CLK_ON: begin
        reg_we    = 1'b1;
        sel       = SEL_CTRL;
        reg_wdata = shadow_q & ~CLK_MASK;
        state_d   = S_RUN;
      end
      S_RUN: begin
        reg_we    = 1'b1;
        sel       = SEL_CTRL;
        reg_wdata = shadow_q & ~(CLK_MASK | RST_MASK);
        state_d   = S_DONE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      err_q    <= ERR_NONE;
      cnt_q    <= '0;
      hidx_q   <= '0;
      big_q    <= 1'b0;
      isz_q    <= '0;
      dsz_q    <= '0;
      len_q    <= '0;
      shadow_q <= '0;
    end else begin
      state_q  <= state_d;
      err_q    <= err_d;
      cnt_q    <= cnt_d;
      hidx_q   <= hidx_d;
      big_q    <= big_d;
      isz_q    <= isz_d;
      dsz_q    <= dsz_d;
      len_q    <= len_d;
      shadow_q <= shadow_d;
    end
  end

  assign imem_addr = cnt_q[IMEM_AW-1:0];
  assign dmem_addr = cnt_q[DMEM_AW-1:0];
  assign reg_sel   = sel;
  assign busy      = (state_q != S_IDLE) && (state_q != S_DONE);
  assign done      = (state_q == S_DONE);
  assign err_code  = err_q;

  // R9: a finished result is held until the next start pulse
  p_result_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(err_code)));

  // R9: no stream handshake outside a load
  p_ready_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !s_ready);

  // R1: an unknown first word ends the load with the magic error
  p_bad_magic_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_HDR && hidx_q == 3'd0 && acc &&
     s_data != MAGIC_LE && s_data != MAGIC_BE) |=> (done && err_code == ERR_MAGIC));

  // R7: after any error the block makes no further writes
  p_quiet_on_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (err_code != ERR_NONE) |-> !(imem_we || dmem_we || reg_we));

  // R8: the reset release write is directly preceded by the clock enable write
  p_release_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_sel == SEL_CTRL && !reg_wdata[CTRL_RST_BIT]) |->
      $past(reg_we && reg_sel == SEL_CTRL && !reg_wdata[CTRL_CLKOFF_BIT]));

endmodule

// File: tb/sim_cpfw_loader.sv
module sim_cpfw_loader;
  localparam int IAW = 4;
  localparam int DAW = 3;
  localparam int ID  = 1 << IAW;
  localparam int DD  = 1 << DAW;
  localparam logic [31:0] MLE  = 32'hfe0101fe;
  localparam logic [31:0] MBE  = 32'hfe1010fe;
  localparam logic [31:0] SENT = 32'hdead_beef;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [31:0] img_len = '0;
  logic s_valid, s_ready;
  logic [31:0] s_data;
  logic imem_we, dmem_we, reg_we, busy, done;
  logic [IAW-1:0] imem_addr;
  logic [DAW-1:0] dmem_addr;
  logic [31:0] imem_wdata, dmem_wdata, reg_wdata;
  logic [1:0] reg_sel, err_code;
  logic [31:0] ctrl_m, mbcp_m, mbhost_m;

  always #5 clk = ~clk;

  cpfw_loader #(.IMEM_AW(IAW), .DMEM_AW(DAW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .img_len(img_len),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .imem_we(imem_we), .imem_addr(imem_addr), .imem_wdata(imem_wdata),
    .dmem_we(dmem_we), .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata),
    .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .cp_ctrl_q(ctrl_m), .busy(busy), .done(done), .err_code(err_code));

  int total = 0;
  int bad = 0;

  logic [31:0] nat [64];
  logic [31:0] img [64];
  int n_words, ni_g, nd_g;
  int idx;
  logic feed = 1'b0;

  assign s_valid = feed && (idx < n_words);
  assign s_data  = (idx < 64) ? img[idx] : 32'h0;

  always @(posedge clk) if (s_valid && s_ready) idx <= idx + 1;

  logic [31:0] im [ID];
  logic [31:0] dm [DD];
  bit iseen [ID];
  bit dseen [DD];
  bit zbad;
  logic [1:0]  rl_sel [8];
  logic [31:0] rl_dat [8];
  int rl_n;
  logic [1:0]  e_sel [8];
  logic [31:0] e_dat [8];
  int e_n;

  always @(posedge clk) begin
    if (imem_we) begin
      if (!iseen[imem_addr]) begin
        iseen[imem_addr] = 1'b1;
        if (imem_wdata != 0) zbad = 1'b1;
      end
      im[imem_addr] = imem_wdata;
    end
    if (dmem_we) begin
      if (!dseen[dmem_addr]) begin
        dseen[dmem_addr] = 1'b1;
        if (dmem_wdata != 0) zbad = 1'b1;
      end
      dm[dmem_addr] = dmem_wdata;
    end
    if (reg_we) begin
      if (rl_n < 8) begin
        rl_sel[rl_n] = reg_sel;
        rl_dat[rl_n] = reg_wdata;
      end
      rl_n = rl_n + 1;
      case (reg_sel)
        2'd0: ctrl_m = reg_wdata;
        2'd1: mbcp_m = reg_wdata;
        2'd2: mbhost_m = reg_wdata;
        default: ;
      endcase
    end
  end

  function automatic logic [31:0] bswap(input logic [31:0] x);
    return {x[7:0], x[15:8], x[23:16], x[31:24]};
  endfunction

  task automatic chk(input bit ok, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  task automatic make_img(input bit big, input int ni, input int nd);
    logic [31:0] s;
    int last;
    nat[0] = big ? MBE : MLE;
    nat[1] = $urandom();
    nat[2] = $urandom();
    nat[3] = ni * 4;
    nat[4] = nd * 4;
    last = 5 + ni + nd;
    for (int k = 5; k < last; k++) nat[k] = $urandom();
    s = '0;
    for (int k = 0; k < last; k++) s = s + nat[k];
    nat[last] = s;
    n_words = last + 1;
    for (int k = 0; k < n_words; k++) img[k] = big ? bswap(nat[k]) : nat[k];
    ni_g = ni;
    nd_g = nd;
  endtask

  task automatic push(input logic [1:0] s, input logic [31:0] d);
    e_sel[e_n] = s;
    e_dat[e_n] = d;
    e_n++;
  endtask

  task automatic run(input logic [31:0] len, input logic [31:0] c0);
    int guard;
    @(negedge clk);
    for (int a = 0; a < ID; a++) begin im[a] = SENT; iseen[a] = 1'b0; end
    for (int a = 0; a < DD; a++) begin dm[a] = SENT; dseen[a] = 1'b0; end
    zbad = 1'b0;
    rl_n = 0;
    ctrl_m = c0;
    mbcp_m = SENT;
    mbhost_m = SENT;
    idx = 0;
    feed = 1'b1;
    img_len = len;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    guard = 0;
    while (!done && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    feed = 1'b0;
    chk(done, "R9 load finishes", {31'b0, done}, 32'h1);
  endtask

  task automatic cmp_log(input string tag);
    chk(rl_n == e_n, {tag, " register write count"}, rl_n, e_n);
    for (int k = 0; k < e_n && k < rl_n; k++)
      chk(rl_sel[k] == e_sel[k] && rl_dat[k] == e_dat[k], {tag, " register write"},
          {rl_sel[k], rl_dat[k][29:0]}, {e_sel[k], e_dat[k][29:0]});
  endtask

  task automatic check_mem();
    int mis;
    mis = 0;
    for (int a = 0; a < ID; a++)
      if (im[a] !== ((a < ni_g) ? nat[5 + a] : SENT)) mis++;
    chk(mis == 0, "R4 R2 instruction memory contents", mis, 0);
    mis = 0;
    for (int a = 0; a < DD; a++)
      if (dm[a] !== ((a < nd_g) ? nat[5 + ni_g + a] : SENT)) mis++;
    chk(mis == 0, "R4 R10 data memory contents", mis, 0);
    chk(!zbad, "R5 first write to each address is zero", {31'b0, zbad}, 0);
  endtask

  task automatic expect_ok(input logic [31:0] c0, input string tag);
    logic [31:0] c;
    chk(err_code == 2'd0, {tag, " R8 success code"}, err_code, 0);
    check_mem();
    e_n = 0;
    c = c0;
    if (!c0[0]) begin
      push(2'd0, c0 | 32'h1);   // R6 halt write
      c = c0 | 32'h1;
    end
    push(2'd1, 32'h0);
    push(2'd2, 32'h0);
    push(2'd0, c & ~32'h4);
    push(2'd0, c & ~32'h5);
    cmp_log({tag, " R6 R8"});
    chk(ctrl_m == (c & ~32'h5), "R8 control released", ctrl_m, c & ~32'h5);
    chk(mbcp_m == 0 && mbhost_m == 0, "R8 mailboxes cleared", mbcp_m | mbhost_m, 0);
  endtask

  task automatic expect_quiet(input logic [1:0] code, input string tag);
    int touched;
    chk(err_code == code, {tag, " error code"}, err_code, code);
    e_n = 0;
    cmp_log({tag, " no register write"});
    touched = 0;
    for (int a = 0; a < ID; a++) if (iseen[a]) touched++;
    for (int a = 0; a < DD; a++) if (dseen[a]) touched++;
    chk(touched == 0, {tag, " no memory write"}, touched, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired act=%h exp=%h", 32'h0, 32'h1);
    summary();
    $finish;
  end

  initial begin
    logic [31:0] c0;
    logic [1:0] hold;
    void'($urandom(32'd2024));
    n_words = 0;
    idx = 0;
    ctrl_m = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && !busy && !s_ready && !imem_we && !dmem_we && !reg_we,
        "R9 reset state", {done, busy, s_ready}, 0);

    // R1 R6 R8: native order image, coprocessor running
    make_img(1'b0, 5, 3);
    run(n_words * 4, 32'h0000_00a4);
    expect_ok(32'h0000_00a4, "R1 little-endian");

    // R2: byte-reversed image
    make_img(1'b1, 7, 4);
    run(n_words * 4, 32'h0000_0004);
    expect_ok(32'h0000_0004, "R2 big-endian");

    // R9: result held until next start
    hold = err_code;
    repeat (5) @(negedge clk);
    chk(done && err_code == hold && !s_ready && !busy, "R9 result held", err_code, hold);

    // R6: coprocessor already held in reset -> no halt write
    make_img(1'b0, 2, 2);
    run(n_words * 4, 32'h0000_0015);
    expect_ok(32'h0000_0015, "R6 already halted");

    // R1: bad magic
    make_img(1'b0, 2, 2);
    img[0] = 32'h1234_5678;
    run(n_words * 4, 32'h0);
    expect_quiet(2'd1, "R1 bad magic");
    chk(idx == 1, "R1 only the magic word consumed", idx, 1);

    // R3: total length mismatch
    make_img(1'b0, 3, 1);
    run(n_words * 4 + 4, 32'h0);
    expect_quiet(2'd2, "R3 length mismatch");

    // R3: section size not a multiple of 4
    make_img(1'b0, 3, 1);
    img[3] = 32'd14;
    run(n_words * 4, 32'h0);
    expect_quiet(2'd2, "R3 unaligned size");

    // R3: instruction section larger than its memory (big-endian header)
    make_img(1'b1, ID + 1, 0);
    run(n_words * 4, 32'h0);
    expect_quiet(2'd2, "R3 instruction overflow");

    // R3: data section larger than its memory
    make_img(1'b0, 0, DD + 1);
    run(n_words * 4, 32'h0);
    expect_quiet(2'd2, "R3 data overflow");

    // R3 R4: both memories filled exactly
    make_img(1'b1, ID, DD);
    run(n_words * 4, 32'h0);
    expect_ok(32'h0, "R4 full depth");

    // R10: both sections empty
    make_img(1'b0, 0, 0);
    run(n_words * 4, 32'h0000_0004);
    expect_ok(32'h0000_0004, "R10 empty sections");

    // R7: checksum mismatch, coprocessor running
    make_img(1'b1, 4, 2);
    img[n_words - 1] = img[n_words - 1] ^ 32'h0100_0000;
    run(n_words * 4, 32'h0000_0004);
    chk(err_code == 2'd3, "R7 checksum error code", err_code, 3);
    e_n = 0;
    push(2'd0, 32'h0000_0005);
    cmp_log("R7 only halt write");
    chk(ctrl_m[0] == 1'b1, "R7 coprocessor stays in reset", ctrl_m, 32'h5);
    chk(mbcp_m == SENT && mbhost_m == SENT, "R7 mailboxes untouched", mbcp_m, SENT);

    // random loads
    for (int it = 0; it < 24; it++) begin
      make_img($urandom_range(1, 0) == 1, $urandom_range(ID, 0), $urandom_range(DD, 0));
      c0 = $urandom() & 32'hffff_fffe;
      c0[0] = $urandom_range(1, 0) == 1;
      run(n_words * 4, c0);
      expect_ok(c0, "R2 R4 random");
    end

    summary();
    $finish;
  end
endmodule